// File: doc/BRIEF.md
# Circular and Bit-Reversed Pointer Address Generator

This block produces data-memory addresses for a signal-processing datapath. It holds a pointer, a buffer base and a buffer length. On each request it returns the current pointer as the fetch address and advances the pointer by a signed step. The step is applied in one of three ways. In linear mode it is a plain 32-bit add. In circular mode it stays inside a buffer of length K that starts at the base. In reverse-carry mode the carry runs from the high offset bit toward the low one, which walks the index order that a radix-2 FFT needs.

A second, independent index serves filter delay lines. Each insertion strobe returns the address of the oldest sample slot, which is where the new sample is to be written. The index then moves on by one and wraps after K slots. With this scheme the delay line never has to be shifted element by element. The memory and the filter arithmetic sit outside this block.

Top module: `agu_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `addr_vld` and `ins_vld` are 0 and `ptr_out` and `addr_out` are 0.
- R2: A cycle with `ld_en`=1 loads base, length and pointer. In the next cycle `ptr_out` equals the loaded pointer.
- R3: `ld_en` takes priority over `req` and `ins_req` in the same cycle. In the next cycle `addr_vld` and `ins_vld` are 0 and the pointer takes the loaded value, not a stepped one.
- R4: A `req` in cycle t (without load) gives `addr_vld`=1 in cycle t+1, with `addr_out` equal to the pointer held in cycle t. The updated pointer appears on `ptr_out` in that same cycle t+1.
- R5: `mode` 0 (and the unused code 3) is linear: the new pointer is pointer + step, modulo 2^32.
- R6: `mode` 1 is circular with a non-negative step. If offset + step (offset = pointer − base) reaches K or more, the new pointer is pointer + step − K. Otherwise it is pointer + step.
- R7: `mode` 1 with a negative step: if pointer + step falls below base, the new pointer is pointer + step + K. The step magnitude is assumed below K.
- R8: `mode` 2 is reverse-carry. The low BR_BITS bits of the offset are added to the low BR_BITS bits of the step with the carry moving from the most significant bit downward. A carry out of bit 0 is dropped, and the upper offset bits are kept. With step 2^(BR_BITS−1) from offset 0, the offsets are the bit-reversed counts 0, 8, 4, 12, 2, … for BR_BITS=4.
- R9: An `ins_req` in cycle t (without load) gives `ins_vld`=1 in cycle t+1, with `ins_addr` = base + oldest index. The index then advances by 1, returns to 0 after K−1, and is cleared by a load.
- R10: Without `req` and `ld_en`, the pointer holds its value and `addr_vld` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load base, length and pointer |
| ld_base | input | 32 | Buffer base address |
| ld_len | input | 32 | Buffer length K |
| ld_ptr | input | 32 | Initial pointer |
| mode | input | 2 | 0/3 linear, 1 circular, 2 reverse-carry |
| step | input | 32 | Signed pointer step |
| req | input | 1 | Address request strobe |
| addr_out | output | 32 | Registered fetch address |
| addr_vld | output | 1 | `addr_out` valid |
| ptr_out | output | 32 | Current pointer |
| ins_req | input | 1 | Delay-line insertion strobe |
| ins_addr | output | 32 | Slot address for the new sample |
| ins_vld | output | 1 | `ins_addr` valid |

## Verification
Every result is due exactly one clock edge after its strobe. This holds for the fetch address, the stepped pointer, the insertion address and the loaded pointer. The bench drives each strobe at a falling edge and removes it at the next falling edge. It compares outputs at that same falling edge, which lies half a period after the single register stage. Sequences such as the reverse-carry walk and the insertion wrap repeat this one-edge pattern on every step, so each output is checked in the cycle it first becomes valid.

// File: rtl/agu_pkg.sv
// Shared types for the address generator.
package agu_pkg;
    typedef enum logic [1:0] {
        MD_LINEAR = 2'd0,
        MD_CIRC   = 2'd1,
        MD_REVC   = 2'd2,
        MD_SPARE  = 2'd3
    } agu_mode_e;
endpackage

// File: rtl/agu_circ_step.sv
// Circular step: next pointer inside [base, base+len).
// Assumes ptr already lies in the buffer and |step| < len.
module agu_circ_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] nxt
);
    localparam int WW = AW + 2;

    logic signed [WW-1:0] off_w, step_w, len_w, sum_w, fix_w;

    // Compute the offset sum and fold it back into the buffer.
    always_comb begin
        off_w  = signed'({2'b00, ptr - base});
        step_w = signed'({{2{step[AW-1]}}, step});
        len_w  = signed'({2'b00, len});
        sum_w  = off_w + step_w;
        if (sum_w < 0)
            fix_w = sum_w + len_w;
        else if (sum_w >= len_w)
            fix_w = sum_w - len_w;
        else
            fix_w = sum_w;
        nxt = base + fix_w[AW-1:0];
    end
endmodule

// File: rtl/agu_revc_step.sv
// Reverse-carry step over the low RB offset bits.
// Assumes base is aligned to 2^RB; upper offset bits are kept.
module agu_revc_step #(
    parameter int AW = 32,
    parameter int RB = 4
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] off;
    logic [RB-1:0] off_r, step_r, sum_r, sum_n;

    // Offset of the pointer from the buffer base.
    always_comb off = ptr - base;

    for (genvar i = 0; i < RB; i++) begin : g_rev
        assign off_r[i]  = off[RB-1-i];
        assign step_r[i] = step[RB-1-i];
        assign sum_n[i]  = sum_r[RB-1-i];
    end

    // Add in reversed order and rebuild the pointer.
    always_comb begin
        sum_r = off_r + step_r;
        if (AW > RB)
            nxt = base + {off[AW-1:RB], sum_n};
        else
            nxt = base + AW'(sum_n);
    end
endmodule

// File: rtl/agu_oldest_track.sv
// Oldest-slot index for a circular delay line of length len.
// Each insert returns base+index and advances the index modulo len.
module agu_oldest_track #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ins,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] slot_addr,
    output logic          slot_vld
);
    logic [AW-1:0] idx;
    logic [AW-1:0] idx_inc;

    // Next index with wrap at the buffer length.
    always_comb idx_inc = (idx + 1'b1 >= len) ? '0 : idx + 1'b1;

    // Index register, registered slot address and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            slot_addr <= '0;
            slot_vld  <= 1'b0;
        end else if (clr) begin
            idx       <= '0;
            slot_vld  <= 1'b0;
        end else if (ins) begin
            slot_addr <= base + idx;
            idx       <= idx_inc;
            slot_vld  <= 1'b1;
        end else begin
            slot_vld  <= 1'b0;
        end
    end
endmodule

// File: rtl/agu_addr_gen.sv
// Top: pointer register with linear, circular and reverse-carry
// post-update, plus an independent delay-line insertion index.
// Load has priority over both strobes. Outputs are registered.
module agu_addr_gen
    import agu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int BR_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_base,
    input  logic [AW-1:0] ld_len,
    input  logic [AW-1:0] ld_ptr,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] step,
    input  logic          req,
    output logic [AW-1:0] addr_out,
    output logic          addr_vld,
    output logic [AW-1:0] ptr_out,
    input  logic          ins_req,
    output logic [AW-1:0] ins_addr,
    output logic          ins_vld
);
    logic [AW-1:0] base_q, len_q, ptr_q;
    logic [AW-1:0] nxt_circ, nxt_revc, nxt_ptr;
    agu_mode_e     md;

    agu_circ_step #(.AW(AW)) u_circ (
        .ptr(ptr_q), .base(base_q), .len(len_q), .step(step), .nxt(nxt_circ)
    );

    agu_revc_step #(.AW(AW), .RB(BR_BITS)) u_revc (
        .ptr(ptr_q), .base(base_q), .step(step), .nxt(nxt_revc)
    );

    agu_oldest_track #(.AW(AW)) u_old (
        .clk(clk), .rst_n(rst_n), .clr(ld_en), .ins(ins_req),
        .base(base_q), .len(len_q), .slot_addr(ins_addr), .slot_vld(ins_vld)
    );

    // Select the post-update rule from the mode input.
    always_comb begin
        md = agu_mode_e'(mode);
        case (md)
            MD_CIRC: nxt_ptr = nxt_circ;
            MD_REVC: nxt_ptr = nxt_revc;
            default: nxt_ptr = ptr_q + step;
        endcase
    end

    // Buffer registers, pointer and registered fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            len_q    <= '0;
            ptr_q    <= '0;
            addr_out <= '0;
            addr_vld <= 1'b0;
        end else if (ld_en) begin
            base_q   <= ld_base;
            len_q    <= ld_len;
            ptr_q    <= ld_ptr;
            addr_vld <= 1'b0;
        end else if (req) begin
            addr_out <= ptr_q;
            ptr_q    <= nxt_ptr;
            addr_vld <= 1'b1;
        end else begin
            addr_vld <= 1'b0;
        end
    end

    assign ptr_out = ptr_q;
endmodule

// File: rtl/agu_addr_gen_chk.sv
// Port-level checker for agu_addr_gen, bound to every instance.
module agu_addr_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_en,
    input logic [AW-1:0] ld_base,
    input logic [AW-1:0] ld_len,
    input logic [AW-1:0] ld_ptr,
    input logic [1:0]    mode,
    input logic [AW-1:0] step,
    input logic          req,
    input logic [AW-1:0] addr_out,
    input logic          addr_vld,
    input logic [AW-1:0] ptr_out,
    input logic          ins_req,
    input logic          ins_vld
);
    a_r2_load_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> ptr_out == $past(ld_ptr));

    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (!addr_vld && !ins_vld));

    a_r4_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ld_en) |=> addr_vld);

    a_r4_addr_old_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ld_en) |=> addr_out == $past(ptr_out));

    a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !ld_en) |=> ($stable(ptr_out) && !addr_vld));

    a_r9_ins_vld: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ld_en) |=> ins_vld);

    a_r6_circ_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ld_en && mode == 2'd1 && ld_len == 32'd10 && ld_base == 32'h200
         && ptr_out >= 32'h200 && ptr_out < 32'h20A
         && ($signed(step) < 10) && ($signed(step) > -10))
        |=> (ptr_out >= 32'h200 && ptr_out < 32'h20A));
endmodule

bind agu_addr_gen agu_addr_gen_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_base(ld_base),
    .ld_len(ld_len), .ld_ptr(ld_ptr), .mode(mode), .step(step), .req(req),
    .addr_out(addr_out), .addr_vld(addr_vld), .ptr_out(ptr_out),
    .ins_req(ins_req), .ins_vld(ins_vld)
);

// File: tb/tb_agu_addr_gen.sv
module tb_agu_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_base = '0, ld_len = '0, ld_ptr = '0;
    logic [1:0]  mode = '0;
    logic [31:0] step = '0;
    logic        req = 1'b0, ins_req = 1'b0;
    logic [31:0] addr_out, ptr_out, ins_addr;
    logic        addr_vld, ins_vld;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    agu_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_base(ld_base),
        .ld_len(ld_len), .ld_ptr(ld_ptr), .mode(mode), .step(step), .req(req),
        .addr_out(addr_out), .addr_vld(addr_vld), .ptr_out(ptr_out),
        .ins_req(ins_req), .ins_addr(ins_addr), .ins_vld(ins_vld)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [31:0] base;
        logic [31:0] len;
        logic [31:0] ptr;
        logic [31:0] stp;
        logic [31:0] eptr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'h0,   32'd0,  32'h1000, 32'd4,        32'h1004},     // R5
        '{2'd0, 32'h0,   32'd0,  32'h10,   32'hFFFFFFE0, 32'hFFFFFFF0}, // R5 wrap
        '{2'd3, 32'h0,   32'd0,  32'h5,    32'd3,        32'h8},        // R5 spare code
        '{2'd1, 32'h200, 32'd10, 32'h203,  32'd2,        32'h205},      // R6 inside
        '{2'd1, 32'h200, 32'd10, 32'h208,  32'd2,        32'h200},      // R6 exact end
        '{2'd1, 32'h200, 32'd10, 32'h209,  32'd3,        32'h202},      // R6 past end
        '{2'd1, 32'h200, 32'd10, 32'h201,  32'hFFFFFFFD, 32'h208},      // R7 below base
        '{2'd1, 32'h200, 32'd10, 32'h202,  32'hFFFFFFFE, 32'h200},      // R7 onto base
        '{2'd2, 32'h400, 32'd16, 32'h408,  32'd8,        32'h404},      // R8
        '{2'd2, 32'h400, 32'd16, 32'h40F,  32'd8,        32'h400}       // R8 carry drop
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] b, input logic [31:0] l, input logic [31:0] p);
        @(negedge clk);
        ld_en = 1'b1; ld_base = b; ld_len = l; ld_ptr = p;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic pulse_req(input logic [1:0] m, input logic [31:0] s);
        mode = m; step = s; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 addr_vld", {31'd0, addr_vld}, 32'd0);
        chk("R1 ins_vld", {31'd0, ins_vld}, 32'd0);
        chk("R1 ptr_out", ptr_out, 32'd0);
        chk("R1 addr_out", addr_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {31'd0, addr_vld}, 32'd0);

        // Vector table: R2 load, R4 timing, R5..R8 update rules
        for (int i = 0; i < NV; i++) begin
            load(VEC[i].base, VEC[i].len, VEC[i].ptr);
            chk("R2 loaded ptr", ptr_out, VEC[i].ptr);
            pulse_req(VEC[i].md, VEC[i].stp);
            chk("R4 addr_vld", {31'd0, addr_vld}, 32'd1);
            chk("R4 addr_out", addr_out, VEC[i].ptr);
            chk("R5-R8 new ptr", ptr_out, VEC[i].eptr);
        end

        // R10: no request, pointer holds and valid drops
        @(negedge clk);
        chk("R10 vld low", {31'd0, addr_vld}, 32'd0);
        chk("R10 ptr hold", ptr_out, 32'h400);

        // R8: full bit-reversed walk over 16 points
        load(32'h800, 32'd16, 32'h800);
        for (int k = 0; k < 16; k++) begin
            logic [3:0] cnt, rv;
            cnt = 4'(k);
            rv = {cnt[0], cnt[1], cnt[2], cnt[3]};
            pulse_req(2'd2, 32'd8);
            chk("R8 walk addr", addr_out, 32'h800 + {28'd0, rv});
        end
        chk("R8 walk wraps", ptr_out, 32'h800);

        // R3: load beats req and ins_req in the same cycle
        @(negedge clk);
        ld_en = 1'b1; ld_base = 32'h100; ld_len = 32'd3; ld_ptr = 32'h101;
        req = 1'b1; ins_req = 1'b1; mode = 2'd0; step = 32'd7;
        @(negedge clk);
        ld_en = 1'b0; req = 1'b0; ins_req = 1'b0;
        chk("R3 addr_vld", {31'd0, addr_vld}, 32'd0);
        chk("R3 ins_vld", {31'd0, ins_vld}, 32'd0);
        chk("R3 ptr", ptr_out, 32'h101);

        // R9: insertion slots wrap after K=3
        for (int k = 0; k < 5; k++) begin
            ins_req = 1'b1;
            @(negedge clk);
            ins_req = 1'b0;
            chk("R9 ins_vld", {31'd0, ins_vld}, 32'd1);
            chk("R9 ins_addr", ins_addr, 32'h100 + 32'(k % 3));
        end
        @(negedge clk);
        chk("R9 ins_vld drops", {31'd0, ins_vld}, 32'd0);
        // R9: reload clears the index
        load(32'h100, 32'd3, 32'h100);
        ins_req = 1'b1;
        @(negedge clk);
        ins_req = 1'b0;
        chk("R9 index cleared", ins_addr, 32'h100);

        finish_run();
    end
endmodule